// File: doc/BRIEF.md
# Matrix Scan Timer with Dimming, Flash and Blink Gating

This block produces the refresh timing for an eight-digit display built from 5x7 dot cells. A free-running master clock is divided into scan slots. Each slot addresses one digit, and the row index moves on each time the digit index wraps. Inside a slot, a small state machine opens a column-enable window whose length follows a 3-bit brightness code. The peak drive is the same at every code; only the share of the slot during which the columns are enabled changes.

A single 15-bit phase counter wraps every 28,672 master clocks. The upper half of its count is the "off" phase. While the off phase lasts, the enable is forced low for any digit that has its mask bit set, provided per-digit flashing is switched on. When whole-display blinking is switched on, the enable is forced low for every digit, whatever the mask holds. The five column bits for the addressed digit and row come from an external font lookup, and the block gates them with the enable. All counters clear on a synchronous reset, so several instances that share one clock and one reset scan in phase.

The slot state machine has three states. SLOT_LIT enables the columns. SLOT_DARK holds them off for the rest of the active sub-ticks. SLOT_GUARD is the final sub-tick of every slot and is always dark. The transitions are:
- LIT to DARK when the lit sub-tick count reaches the latched duty.
- LIT to GUARD when the full duty of 15 runs out.
- DARK to GUARD at the end of sub-tick 14.
- GUARD to LIT or GUARD to DARK at the slot boundary. At that point the brightness code is sampled, and a duty of zero sends the machine to DARK.

Top module: `dref_refresh`

## Requirements
- R1: While reset is held, and on the first cycle after it, the outputs show digit 0 and row 0, and the machine is in SLOT_LIT with a latched duty of 15 sub-ticks (full brightness).
- R2: A slot lasts 224 master clocks, made of 16 sub-ticks of 14 clocks each. The digit index advances by one at every slot boundary and wraps from 7 to 0.
- R3: The row index advances by one only when the digit index wraps from 7 to 0. Rows run from 0 to 6 and then wrap.
- R4: Sub-ticks 0 to 14 form the active part of a slot. Codes 000 to 111 enable the columns for the first 15, 12, 8, 6, 4, 3, 2 or 0 active sub-ticks. Sub-tick 15 is always dark.
- R5: The brightness code is sampled only at the clock edge that starts a slot. A change in the middle of a slot has no effect until the next slot.
- R6: The phase counter runs from 0 to 28,671 and then wraps. The off phase is the count range 14,336 to 28,671.
- R7: With flash enabled (flash_enable=1) and blink disabled, the enable is forced low during the off phase whenever flash_mask bit [digit_sel] is 1. With flash_enable=0, the mask has no effect.
- R8: With blink_enable=1, the enable is forced low for every digit during the off phase, whatever the values of flash_enable and flash_mask.
- R9: col_drive equals font_cols while col_gate is 1, and is all zeros while col_gate is 0.
- R10: A reset applied during operation restarts the slot, digit, row and phase counters from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bright_code | input | 3 | Brightness code (000 full, 111 blank) |
| flash_enable | input | 1 | Per-digit flashing switch |
| blink_enable | input | 1 | Whole-display blinking switch |
| flash_mask | input | 8 | One flash bit per digit; bit n belongs to digit n |
| font_cols | input | 5 | Column pattern from the font lookup for the current digit and row |
| digit_sel | output | 3 | Digit being scanned |
| row_sel | output | 3 | Row being scanned |
| col_gate | output | 1 | Column enable for this cycle |
| col_drive | output | 5 | Gated column pattern |

## Verification
The hardest case to reach is a flash or blink decision right at the edge of the off phase. That edge lies 14,336 clocks into the phase cycle, and the only way to get there is through real time. The bench therefore runs long directed stretches with flashing on and then blinking on, each covering a full phase period. It also runs a random stretch that toggles the switches, the mask and the brightness code at low rates, so that code changes land in the middle of slots and the latched duty differs from the code on the pins. A reference model steps its own position counters, and every cycle is compared against it.

// File: rtl/dref_pkg.sv
package dref_pkg;

    localparam int LIT_TICKS = 15;
    localparam int SUB_W     = 4;

    typedef enum logic [1:0] {
        SLOT_LIT   = 2'd0,
        SLOT_DARK  = 2'd1,
        SLOT_GUARD = 2'd2
    } slot_state_e;

    function automatic logic [SUB_W-1:0] duty_of(input logic [2:0] code);
        logic [SUB_W-1:0] d;
        unique case (code)
            3'd0:    d = 4'd15;
            3'd1:    d = 4'd12;
            3'd2:    d = 4'd8;
            3'd3:    d = 4'd6;
            3'd4:    d = 4'd4;
            3'd5:    d = 4'd3;
            3'd6:    d = 4'd2;
            default: d = 4'd0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/dref_scan_timer.sv
module dref_scan_timer
    import dref_pkg::*;
#(
    parameter int TICK_CLKS = 14,
    parameter int DIGITS    = 8,
    parameter int ROWS      = 7,
    localparam int CNT_W    = $clog2(TICK_CLKS),
    localparam int DIG_W    = $clog2(DIGITS),
    localparam int ROW_W    = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SUB_W-1:0] sub_idx,
    output logic             tick_last,
    output logic [DIG_W-1:0] digit_idx,
    output logic [ROW_W-1:0] row_idx
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_CLKS - 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(LIT_TICKS);
    localparam logic [DIG_W-1:0] DIG_LAST = DIG_W'(DIGITS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [SUB_W-1:0] sub_q;
    logic [DIG_W-1:0] dig_q;
    logic [ROW_W-1:0] row_q;
    logic             slot_last;

    assign tick_last = (cnt_q == CNT_LAST);
    assign slot_last = tick_last && (sub_q == SUB_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sub_q <= '0;
            dig_q <= '0;
            row_q <= '0;
        end else begin
            if (tick_last) begin
                cnt_q <= '0;
                sub_q <= sub_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (slot_last) begin
                if (dig_q == DIG_LAST) begin
                    dig_q <= '0;
                    row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
                end else begin
                    dig_q <= dig_q + 1'b1;
                end
            end
        end
    end

    assign sub_idx   = sub_q;
    assign digit_idx = dig_q;
    assign row_idx   = row_q;

endmodule

// File: rtl/dref_flash_phase.sv
module dref_flash_phase #(
    parameter int FLASH_DIV = 28672,
    localparam int PH_W     = $clog2(FLASH_DIV)
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase_off
);

    localparam logic [PH_W-1:0] PH_LAST = PH_W'(FLASH_DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(FLASH_DIV / 2);

    logic [PH_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else if (ph_q == PH_LAST) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_q + 1'b1;
        end
    end

    assign phase_off = (ph_q >= PH_HALF);

endmodule

// File: rtl/dref_slot_fsm.sv
module dref_slot_fsm
    import dref_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_last,
    input  logic [SUB_W-1:0] sub_idx,
    input  logic [2:0]       bright_code,
    output logic             window_on
);

    localparam logic [SUB_W-1:0] ACT_LAST = SUB_W'(LIT_TICKS - 1);

    slot_state_e      state_q, state_d;
    logic [SUB_W-1:0] duty_q, duty_d, duty_new;
    logic [SUB_W:0]   lit_done;

    assign duty_new = duty_of(bright_code);
    assign lit_done = {1'b0, sub_idx} + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOT_LIT;
            duty_q  <= SUB_W'(LIT_TICKS);
        end else begin
            state_q <= state_d;
            duty_q  <= duty_d;
        end
    end

    always_comb begin
        state_d = state_q;
        duty_d  = duty_q;
        unique case (state_q)
            SLOT_LIT: begin
                if (tick_last) begin
                    if (sub_idx == ACT_LAST) begin
                        state_d = SLOT_GUARD;
                    end else if (lit_done == {1'b0, duty_q}) begin
                        state_d = SLOT_DARK;
                    end
                end
            end
            SLOT_DARK: begin
                if (tick_last && sub_idx == ACT_LAST) begin
                    state_d = SLOT_GUARD;
                end
            end
            SLOT_GUARD: begin
                if (tick_last) begin
                    duty_d  = duty_new;
                    state_d = (duty_new != '0) ? SLOT_LIT : SLOT_DARK;
                end
            end
            default: state_d = SLOT_DARK;
        endcase
    end

    always_comb begin
        window_on = (state_q == SLOT_LIT);
    end

endmodule

// File: rtl/dref_refresh.sv
module dref_refresh
    import dref_pkg::*;
#(
    parameter int TICK_CLKS = 14,
    parameter int DIGITS    = 8,
    parameter int ROWS      = 7,
    parameter int COLS      = 5,
    parameter int FLASH_DIV = 28672,
    localparam int DIG_W    = $clog2(DIGITS),
    localparam int ROW_W    = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        bright_code,
    input  logic              flash_enable,
    input  logic              blink_enable,
    input  logic [DIGITS-1:0] flash_mask,
    input  logic [COLS-1:0]   font_cols,
    output logic [DIG_W-1:0]  digit_sel,
    output logic [ROW_W-1:0]  row_sel,
    output logic              col_gate,
    output logic [COLS-1:0]   col_drive
);

    logic [SUB_W-1:0] sub_idx;
    logic             tick_last;
    logic             phase_off;
    logic             window_on;
    logic             suppress;

    dref_scan_timer #(
        .TICK_CLKS(TICK_CLKS),
        .DIGITS   (DIGITS),
        .ROWS     (ROWS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub_idx  (sub_idx),
        .tick_last(tick_last),
        .digit_idx(digit_sel),
        .row_idx  (row_sel)
    );

    dref_flash_phase #(
        .FLASH_DIV(FLASH_DIV)
    ) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_off(phase_off)
    );

    dref_slot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_last  (tick_last),
        .sub_idx    (sub_idx),
        .bright_code(bright_code),
        .window_on  (window_on)
    );

    always_comb begin
        if (blink_enable) begin
            suppress = phase_off;
        end else begin
            suppress = flash_enable && flash_mask[digit_sel] && phase_off;
        end
        col_gate  = window_on && !suppress;
        col_drive = font_cols & {COLS{col_gate}};
    end

endmodule

// File: rtl/dref_refresh_chk.sv
module dref_refresh_chk
    import dref_pkg::*;
#(
    parameter int DIGITS = 8,
    parameter int DIG_W  = 3,
    parameter int ROW_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        bright_code,
    input logic              flash_enable,
    input logic              blink_enable,
    input logic [DIGITS-1:0] flash_mask,
    input logic [DIG_W-1:0]  digit_sel,
    input logic [ROW_W-1:0]  row_sel,
    input logic              col_gate,
    input logic [SUB_W-1:0]  sub_idx,
    input logic              phase_off
);

    AST_DIGIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(digit_sel) |-> int'(digit_sel) == (int'($past(digit_sel)) + 1) % DIGITS); // R2

    AST_ROW_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(row_sel) |-> digit_sel == '0); // R3

    AST_GUARD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        sub_idx == SUB_W'(LIT_TICKS) |-> !col_gate); // R4

    AST_BLANK_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bright_code) == 3'd7 && $past(sub_idx) == SUB_W'(LIT_TICKS) && sub_idx == '0)
        |-> !col_gate); // R5

    AST_FLASH_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_enable && !blink_enable && phase_off && flash_mask[digit_sel]) |-> !col_gate); // R7

    AST_BLINK_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_enable && phase_off) |-> !col_gate); // R8

endmodule

bind dref_refresh dref_refresh_chk #(
    .DIGITS(DIGITS),
    .DIG_W (DIG_W),
    .ROW_W (ROW_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bright_code (bright_code),
    .flash_enable(flash_enable),
    .blink_enable(blink_enable),
    .flash_mask  (flash_mask),
    .digit_sel   (digit_sel),
    .row_sel     (row_sel),
    .col_gate    (col_gate),
    .sub_idx     (sub_idx),
    .phase_off   (phase_off)
);

// File: tb/test_dref_refresh.sv
module test_dref_refresh;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bright_code = 3'd0;
    logic       flash_enable = 1'b0;
    logic       blink_enable = 1'b0;
    logic [7:0] flash_mask = 8'h00;
    logic [4:0] font_cols = 5'h00;
    logic [2:0] digit_sel;
    logic [2:0] row_sel;
    logic       col_gate;
    logic [4:0] col_drive;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int duty_exp = 15;
    int post_rst = 0;
    bit in_reset = 1'b1;
    bit after_mid_reset = 1'b0;

    always #10 clk = ~clk;

    dref_refresh i_dref_refresh (
        .clk         (clk),
        .rst_n       (rst_n),
        .bright_code (bright_code),
        .flash_enable(flash_enable),
        .blink_enable(blink_enable),
        .flash_mask  (flash_mask),
        .font_cols   (font_cols),
        .digit_sel   (digit_sel),
        .row_sel     (row_sel),
        .col_gate    (col_gate),
        .col_drive   (col_drive)
    );

    function automatic int ref_duty(input logic [2:0] c);
        case (c)
            3'd0: return 15;
            3'd1: return 12;
            3'd2: return 8;
            3'd3: return 6;
            3'd4: return 4;
            3'd5: return 3;
            3'd6: return 2;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s cyc=%0d actual=%0d expected=%0d", tag, what, cyc, act, exp);
        end
    endtask

    task automatic step_and_check();
        int  sub, slot, dig, row, ph;
        bit  off, win, supp, gate;
        string tg;
        @(posedge clk);
        if (rst_n) begin
            cyc++;
            post_rst++;
            in_reset = 1'b0;
            if (cyc % 224 == 0) duty_exp = ref_duty(bright_code);
        end else begin
            cyc = 0;
            post_rst = 0;
            duty_exp = 15;
            in_reset = 1'b1;
        end
        @(negedge clk);
        sub  = (cyc % 224) / 14;
        slot = cyc / 224;
        dig  = slot % 8;
        row  = (slot / 8) % 7;
        ph   = cyc % 28672;
        off  = (ph >= 14336);
        win  = (sub < duty_exp);
        supp = blink_enable ? off : (flash_enable && flash_mask[dig] && off);
        gate = win && !supp;

        if (in_reset || post_rst == 0) tg = "R1";
        else if (after_mid_reset && post_rst < 4) tg = "R10";
        else if (blink_enable && off) tg = "R8";
        else if (flash_enable && off) tg = "R7";
        else if (ph == 14335 || ph == 14336 || ph == 0 || ph == 28671) tg = "R6";
        else if (ref_duty(bright_code) != duty_exp) tg = "R5";
        else tg = "R4";

        chk((tg == "R1" || tg == "R10") ? tg : "R2", "digit_sel", int'(digit_sel), dig);
        chk((tg == "R1" || tg == "R10") ? tg : "R3", "row_sel", int'(row_sel), row);
        chk(tg, "col_gate", int'(col_gate), int'(gate));
        chk("R9", "col_drive", int'(col_drive), gate ? int'(font_cols) : 0);
    endtask

    task automatic run_random(input int n, input bit allow_switch);
        for (int i = 0; i < n; i++) begin
            step_and_check();
            font_cols = 5'($urandom);
            if ($urandom % 400 == 0) bright_code = 3'($urandom);
            if ($urandom % 700 == 0) flash_mask = 8'($urandom);
            if (allow_switch && $urandom % 3000 == 0) flash_enable = ~flash_enable;
            if (allow_switch && $urandom % 6000 == 0) blink_enable = ~blink_enable;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        for (int i = 0; i < 4; i++) step_and_check();
        rst_n = 1'b1;
        // R4: sweep every brightness code over two slots each
        for (int c = 0; c < 8; c++) begin
            bright_code = 3'(c);
            for (int i = 0; i < 448; i++) begin
                step_and_check();
                font_cols = 5'($urandom);
            end
        end
        // R5: code change in the middle of a slot
        bright_code = 3'd0;
        for (int i = 0; i < 300; i++) step_and_check();
        bright_code = 3'd7;
        for (int i = 0; i < 300; i++) step_and_check();
        // R6, R7: flashing over a full phase period, mask changes
        bright_code  = 3'd0;
        flash_enable = 1'b1;
        flash_mask   = 8'hA5;
        run_random(30000, 1'b0);
        // R7: mask ignored when flashing is off
        flash_enable = 1'b0;
        flash_mask   = 8'hFF;
        run_random(16000, 1'b0);
        // R8: blink overrides flash
        flash_enable = 1'b1;
        blink_enable = 1'b1;
        run_random(30000, 1'b0);
        // mixed random stretch
        blink_enable = 1'b0;
        run_random(40000, 1'b1);
        // R10: reset in mid operation
        rst_n = 1'b0;
        after_mid_reset = 1'b1;
        for (int i = 0; i < 3; i++) step_and_check();
        rst_n = 1'b1;
        run_random(3000, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule